// File: doc/BRIEF.md
# Four-Bit Select-Driven ALU

This block is a purely combinational arithmetic and logic unit for narrow datapaths. It takes two operands and a two-bit operation code and returns a result that is one bit wider than the operands. The extra top bit carries the arithmetic carry, or the no-borrow flag.

Addition and subtraction share one ripple carry chain. In subtract mode every bit of the second operand is inverted, and a carry of one is injected at the bottom of the chain. A bitwise AND unit and a one-place logical shifter sit beside the adder, and a four-way multiplexer picks the result.

The shifter has its own two-bit control: pass, pass, right or left. Inside the ALU that control is wired to the operation code, so the shift operation always moves the first operand one place to the left.

Top module: `nibble_alu`

## Requirements
- R1: The operation code `op_sel` (bit 1 is the upper select line) decodes as follows: 2'b00 adds, 2'b01 subtracts, 2'b10 is a bitwise AND, and 2'b11 shifts.
- R2: For code 2'b00, `result` equals the W+1-bit sum of `a` and `b`, with the carry out in bit W.
- R3: For code 2'b01, `result[W-1:0]` equals `a` minus `b` modulo 2^W. `result[W]` is 1 exactly when `a` >= `b` (no borrow). For example, 1010 minus 0101 gives 10101, and `a` minus itself gives 1 followed by zeros.
- R4: For code 2'b10, `result[W-1:0]` equals `a & b`. For example, 1010 AND 0101 gives 0000.
- R5: For code 2'b11, `result[W-1:0]` equals `a` shifted left by one place with a zero in bit 0. In this mode `b` has no effect. For example, 1010 gives 0100.
- R6: For codes 2'b10 and 2'b11, `result[W]` is 0.
- R7: The shifter submodule `bitshift_unit` passes its data through unchanged for control 2'b00 and 2'b01. Control 2'b10 shifts right with a zero in the MSB, and 2'b11 shifts left with a zero in the LSB. For example, 1101 gives 0110 on a right shift and 1010 on a left shift.
- R8: The output follows any input change without a clock edge.
- R9: The operand width is the parameter W, which defaults to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | W | First operand; also the shifter's data |
| b | input | W | Second operand |
| op_sel | input | 2 | Operation code |
| result | output | W+1 | Carry or no-borrow bit above the data result |

## Verification
The bench builds the block at the default W=4. At that width the whole input space of 4 x 2^8 combinations is small enough to compare in full against a reference model written from the requirements. That sweep reaches every carry and borrow pattern at the top of the chain, every fill bit of the shift, and every case where B is ignored. A separate shifter instance covers its two pass-through codes and the right shift, which the ALU itself never selects.

// File: rtl/nibble_alu_pkg.sv
// Shared operation and shifter control codes for the nibble ALU.
// Assumes a two-bit code; bit 1 is the upper select line.
package nibble_alu_pkg;
    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_AND = 2'b10,
        OP_SHL = 2'b11
    } alu_op_e;

    localparam logic [1:0] SH_RIGHT = 2'b10;
    localparam logic [1:0] SH_LEFT  = 2'b11;
endpackage

// File: rtl/ripple_addsub.sv
// Ripple-carry adder/subtractor. The mode bit inverts the second operand
// and is injected as the carry in, so mode 1 forms a + ~b + 1.
// Assumes W >= 1; carry out is 1 when a subtraction needs no borrow.
module ripple_addsub #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         mode_sub,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0]   chain;
    logic [W-1:0] b_eff;

    assign chain[0] = mode_sub;

    // One full-adder cell per bit position.
    for (genvar i = 0; i < W; i++) begin : g_cell
        assign b_eff[i]   = b[i] ^ mode_sub;
        assign sum[i]     = a[i] ^ b_eff[i] ^ chain[i];
        assign chain[i+1] = (a[i] & b_eff[i]) | (chain[i] & (a[i] ^ b_eff[i]));
    end

    assign cout = chain[W];
endmodule

// File: rtl/bitshift_unit.sv
// One-place logical shifter with its own two-bit control:
// 00/01 pass, 10 right (zero into MSB), 11 left (zero into LSB).
// Assumes W >= 2.
module bitshift_unit
    import nibble_alu_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] data_i,
    input  logic [1:0]   ctl_i,
    output logic [W-1:0] data_o
);
    // Select the shifted or unchanged operand.
    always_comb begin
        case (ctl_i)
            SH_RIGHT: data_o = {1'b0, data_i[W-1:1]};
            SH_LEFT:  data_o = {data_i[W-2:0], 1'b0};
            default:  data_o = data_i;
        endcase
    end
endmodule

// File: rtl/result_mux.sv
// Four-way result selector; forces the top bit to zero for the
// non-arithmetic operations. Assumes the inputs settle combinationally.
module result_mux
    import nibble_alu_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [1:0]   op_sel,
    input  logic [W-1:0] arith_val,
    input  logic         arith_carry,
    input  logic [W-1:0] and_val,
    input  logic [W-1:0] shift_val,
    output logic [W:0]   result
);
    // Route the chosen unit to the output.
    always_comb begin
        case (alu_op_e'(op_sel))
            OP_ADD,
            OP_SUB:  result = {arith_carry, arith_val};
            OP_AND:  result = {1'b0, and_val};
            default: result = {1'b0, shift_val};
        endcase
    end
endmodule

// File: rtl/nibble_alu.sv
// Combinational ALU: add, subtract, bitwise AND, one-place left shift.
// The shifter's control is tied to op_sel, so the shift code always
// shifts left. No clock and no state.
module nibble_alu #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   op_sel,
    output logic [W:0]   result
);
    logic [W-1:0] arith_val;
    logic         arith_carry;
    logic [W-1:0] and_val;
    logic [W-1:0] shift_val;

    ripple_addsub #(.W(W)) u_addsub (
        .a(a), .b(b), .mode_sub(op_sel[0]),
        .sum(arith_val), .cout(arith_carry)
    );

    // Bitwise logic unit.
    assign and_val = a & b;

    bitshift_unit #(.W(W)) u_shift (
        .data_i(a), .ctl_i(op_sel), .data_o(shift_val)
    );

    result_mux #(.W(W)) u_mux (
        .op_sel(op_sel), .arith_val(arith_val), .arith_carry(arith_carry),
        .and_val(and_val), .shift_val(shift_val), .result(result)
    );
endmodule

// File: rtl/nibble_alu_chk.sv
// Port-level checker for nibble_alu. It uses immediate assertions
// because the block has no clock.
module nibble_alu_chk #(
    parameter int W = 4
) (
    input logic [W-1:0] a,
    input logic [W-1:0] b,
    input logic [1:0]   op_sel,
    input logic [W:0]   result
);
    // Evaluate the properties on every input or output change.
    always_comb begin
        if (!$isunknown({a, b, op_sel, result})) begin
            p_no_top_bit_r6: assert (!(op_sel[1] && result[W]))
                else $error("top bit set in non-arith mode");
            p_and_subset_r4: assert (!(op_sel == 2'b10) ||
                                     ((result[W-1:0] & ~(a & b)) == '0))
                else $error("AND result has bits outside a&b");
            p_shift_fill_r5: assert (!(op_sel == 2'b11) ||
                                     (result[0] == 1'b0 && result[W-1:1] == a[W-2:0]))
                else $error("shift result wrong");
            p_add_zero_r2: assert (!(op_sel == 2'b00 && b == '0) ||
                                   (result == {1'b0, a}))
                else $error("adding zero changed operand");
            p_sub_self_r3: assert (!(op_sel == 2'b01 && a == b) ||
                                   (result == {1'b1, {W{1'b0}}}))
                else $error("a-a wrong");
        end
    end
endmodule

bind nibble_alu nibble_alu_chk #(.W(W)) u_chk (
    .a(a), .b(b), .op_sel(op_sel), .result(result)
);

// File: tb/test_nibble_alu.sv
module test_nibble_alu;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a = '0, b = '0, sh_d = '0;
    logic [1:0]   op_sel = 2'b00, sh_c = 2'b00;
    logic [W:0]   result;
    logic [W-1:0] sh_o;
    int           n_chk = 0, n_fail = 0, cycles = 0;

    always #5 clk = ~clk;

    nibble_alu #(.W(W)) i_nibble_alu (.a(a), .b(b), .op_sel(op_sel), .result(result));
    bitshift_unit #(.W(W)) i_shifter (.data_i(sh_d), .ctl_i(sh_c), .data_o(sh_o));

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    // Reference model written from the requirements.
    function automatic logic [W:0] ref_alu(input logic [1:0] op, input logic [W-1:0] x, input logic [W-1:0] y);
        case (op)
            2'b00: ref_alu = {1'b0, x} + {1'b0, y};
            2'b01: ref_alu = {(x >= y) ? 1'b1 : 1'b0, W'(x - y)};
            2'b10: ref_alu = {1'b0, x & y};
            default: ref_alu = {1'b0, x[W-2:0], 1'b0};
        endcase
    endfunction

    task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] op, input logic [W-1:0] x, input logic [W-1:0] y);
        @(negedge clk);
        op_sel = op; a = x; b = y;
        #2;
    endtask

    // Idle state after reset: zero operands add to zero (R2).
    task automatic t_reset_state();
        apply(2'b00, '0, '0);
        check("R2 idle", result, '0);
    endtask

    // Worked examples for each operation (R1-style code use, R3, R4, R5).
    task automatic t_examples();
        apply(2'b00, 4'b1010, 4'b0101); check("R1 add 1010+0101", result, 5'b01111);
        apply(2'b00, 4'b1111, 4'b0001); check("R2 carry out", result, 5'b10000);
        apply(2'b01, 4'b1010, 4'b0101); check("R3 1010-0101", result, 5'b10101);
        apply(2'b01, 4'b0011, 4'b0101); check("R3 borrow", result, 5'b01110);
        apply(2'b01, 4'b0110, 4'b0110); check("R3 self", result, 5'b10000);
        apply(2'b10, 4'b1010, 4'b0101); check("R4 disjoint", result, 5'b00000);
        apply(2'b10, 4'b1110, 4'b0111); check("R4 overlap", result, 5'b00110);
        apply(2'b11, 4'b1010, 4'b0101); check("R5 1010 left", result, 5'b00100);
        apply(2'b11, 4'b1010, 4'b1111); check("R5 b ignored", result, 5'b00100);
        apply(2'b11, 4'b1111, 4'b0000); check("R6 shift top bit", result, 5'b01110);
        apply(2'b10, 4'b1111, 4'b1111); check("R6 AND top bit", result, 5'b01111);
    endtask

    // Output changes with inputs and no clock edge in between (R8).
    task automatic t_comb();
        @(negedge clk);
        op_sel = 2'b00; a = 4'd3; b = 4'd4;
        #1 check("R8 first", result, 5'd7);
        a = 4'd9;
        #1 check("R8 second", result, 5'd13);
    endtask

    // Standalone shifter, all four control codes (R7).
    task automatic t_shifter();
        sh_d = 4'b1101;
        sh_c = 2'b00; #1 check("R7 pass 00", {1'b0, sh_o}, 5'b01101);
        sh_c = 2'b01; #1 check("R7 pass 01", {1'b0, sh_o}, 5'b01101);
        sh_c = 2'b10; #1 check("R7 right", {1'b0, sh_o}, 5'b00110);
        sh_c = 2'b11; #1 check("R7 left", {1'b0, sh_o}, 5'b01010);
    endtask

    // Every code and operand pair against the model at W=4 (R9).
    task automatic t_exhaustive();
        for (int o = 0; o < 4; o++)
            for (int x = 0; x < (1 << W); x++)
                for (int y = 0; y < (1 << W); y++) begin
                    apply(2'(o), W'(x), W'(y));
                    check("R9 sweep", result, ref_alu(2'(o), W'(x), W'(y)));
                end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_examples();
        t_comb();
        t_shifter();
        t_exhaustive();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule